// File: doc/BRIEF.md
# Successive-Approximation Converter Control Core

This block is the digital half of a 12-bit successive-approximation analog-to-digital converter. It watches a host's active-low chip-select and read strobes and an active-high byte-select line. A fresh select-and-read with the byte select low launches a conversion. While the conversion runs, the block drives an active-low busy flag and steps a successive-approximation register from the top bit down. It presents each trial word to an external comparator and keeps or drops each bit according to the comparator's single decision line. When the last bit is settled, the word is copied into an output latch.

The host reads the latch through a 12-bit output path with an enable. With the byte select high, the same path folds the top four result bits onto the low four pins, so a byte-wide host can fetch the word in two reads. The byte select also stops such a read from starting a conversion. A read issued while a conversion is under way returns the previously latched word. This lets a host use each read both to collect the last result and to trigger the next one.

Top module: `sar_ctrl_core`

## Requirements
- R1: A conversion is launched only on a clock edge where cs_n and rd_n are both sampled low, at least one of them was sampled high on the previous edge, and hbyte is sampled low. With hbyte high, or with only one strobe low, busy_n stays high.
- R2: While a conversion is running, new select-and-read edges are ignored: the conversion is not restarted and its length is unchanged.
- R3: busy_n falls on the edge that detects the launch and stays low for exactly 13 clock cycles. It returns high on the same edge that loads the new result into the latch.
- R4: On the launch edge the trial word is cleared to 0x000. One cycle later it holds only bit 11 set (0x800). The bits are then resolved one per cycle from bit 11 down to bit 0.
- R5: A trial bit is kept when the comparator reports the input at or above the trial word, and cleared otherwise. With a comparator that reports (input code >= trial word), the latched result equals the input code, including 0x000 and 0xFFF.
- R6: data_oe is 1 exactly while cs_n and rd_n are both low. When data_oe is 0, data_o is driven to all zeros; an enclosing pad ring takes this as high impedance.
- R7: With hbyte low, data_o[11:0] equals the result. With hbyte high, data_o[11:8] and data_o[3:0] both carry result[11:8], and data_o[7:4] is 0.
- R8: Throughout a conversion the latch and the data path keep showing the previously completed result.
- R9: After reset, busy_n is 1, the trial word is 0 and the latch holds 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| hbyte | input | 1 | High-byte select; also blocks conversion launch |
| cmp_hi | input | 1 | Comparator decision: 1 when the input is at or above trial_code |
| trial_code | output | 12 | Current trial word driven to the comparator/DAC |
| busy_n | output | 1 | Low while a conversion is in progress |
| data_o | output | 12 | Read data, after byte folding |
| data_oe | output | 1 | Output driver enable |

## Verification
The two functions that can fall in the same cycle are a host read that is also a valid launch request, and a conversion already in progress. The bench provokes this by pulling cs_n and rd_n low again partway through a conversion, at random and at fixed points. It then requires three things: busy_n stays low for exactly 13 cycles, the data path shows the old word during that read, and the final result still matches the input code. The closing edge of a conversion, where the latch loads and busy_n rises together, is judged by reading back with hbyte high straight after busy_n returns.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int RES_W  = 12;
    localparam int NIB_W  = 4;
    localparam int IDX_W  = $clog2(RES_W);
    localparam int CONV_CYC = RES_W + 1;

    typedef logic [RES_W-1:0] word_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_DECIDE = 2'd2
    } seq_st_e;

    typedef struct packed {
        seq_st_e st;
        idx_t    idx;
        word_t   sar;
        word_t   result;
        logic    busy_n;
    } seq_regs_t;

    // Fold the result onto the bus according to the byte select.
    function automatic word_t bus_view(word_t w, logic hb);
        word_t v;
        if (!hb) begin
            v = w;
        end else begin
            v = '0;
            v[RES_W-1 -: NIB_W] = w[RES_W-1 -: NIB_W];
            v[NIB_W-1:0]        = w[RES_W-1 -: NIB_W];
        end
        return v;
    endfunction

    // Resolve bit idx with the comparator decision and arm the next trial bit.
    function automatic word_t sar_step(word_t s, idx_t idx, logic keep);
        word_t r;
        r = s;
        r[idx] = keep;
        if (idx != '0) r[idx - 1'b1] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/sar_start_det.sv
module sar_start_det (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rd_n,
    input  logic hbyte,
    output logic start
);
    logic sel_now;
    logic sel_q;

    assign sel_now = ~cs_n & ~rd_n;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= 1'b0;
        else     sel_q <= sel_now;
    end

    // Fresh select/read edge with the byte select low.
    assign start = sel_now & ~sel_q & ~hbyte;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  cmp_hi,
    output word_t trial,
    output word_t result,
    output logic  busy_n
);
    seq_regs_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.sar    = '0;
                    d.busy_n = 1'b0;
                    d.st     = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                d.sar          = '0;
                d.sar[RES_W-1] = 1'b1;
                d.idx          = idx_t'(RES_W - 1);
                d.st           = ST_DECIDE;
            end
            ST_DECIDE: begin
                d.sar = sar_step(q.sar, q.idx, cmp_hi);
                if (q.idx == '0) begin
                    d.result = d.sar;
                    d.busy_n = 1'b1;
                    d.st     = ST_IDLE;
                end else begin
                    d.idx = q.idx - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st     <= ST_IDLE;
            q.idx    <= '0;
            q.sar    <= '0;
            q.result <= '0;
            q.busy_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign trial  = q.sar;
    assign result = q.result;
    assign busy_n = q.busy_n;
endmodule

// File: rtl/sar_bus_mux.sv
module sar_bus_mux
    import sar_pkg::*;
(
    input  logic  cs_n,
    input  logic  rd_n,
    input  logic  hbyte,
    input  word_t result,
    output word_t data_o,
    output logic  data_oe
);
    assign data_oe = ~cs_n & ~rd_n;
    assign data_o  = data_oe ? bus_view(result, hbyte) : '0;
endmodule

// File: rtl/sar_ctrl_core.sv
module sar_ctrl_core
    import sar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              hbyte,
    input  logic              cmp_hi,
    output logic [RES_W-1:0]  trial_code,
    output logic              busy_n,
    output logic [RES_W-1:0]  data_o,
    output logic              data_oe
);
    logic  start;
    word_t result_w;

    sar_start_det u_det (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .rd_n  (rd_n),
        .hbyte (hbyte),
        .start (start)
    );

    sar_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cmp_hi (cmp_hi),
        .trial  (trial_code),
        .result (result_w),
        .busy_n (busy_n)
    );

    sar_bus_mux u_mux (
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .hbyte   (hbyte),
        .result  (result_w),
        .data_o  (data_o),
        .data_oe (data_oe)
    );
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk
    import sar_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             rd_n,
    input logic             hbyte,
    input logic             busy_n,
    input logic [RES_W-1:0] trial_code,
    input logic [RES_W-1:0] data_o,
    input logic             data_oe,
    input logic [RES_W-1:0] result_q
);
    localparam int CNT_W = $clog2(CONV_CYC + 2) + 1;

    logic             sel_prev;
    logic [CNT_W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_prev <= 1'b0;
            low_cnt  <= '0;
        end else begin
            sel_prev <= ~cs_n & ~rd_n;
            low_cnt  <= busy_n ? '0 : low_cnt + 1'b1;
        end
    end

    AST_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (busy_n && !cs_n && !rd_n && !sel_prev && !hbyte) |=> !busy_n); // R1
    AST_HB_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (busy_n && hbyte) |=> busy_n); // R1
    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_n) |-> (low_cnt == CNT_W'(CONV_CYC))); // R3
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (!busy_n && low_cnt < CNT_W'(CONV_CYC - 1)) |=> !busy_n); // R2
    AST_TRIAL_CLR: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_n) |-> (trial_code == '0)); // R4
    AST_TRIAL_MSB: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_n) |=> (trial_code == {1'b1, {(RES_W-1){1'b0}}})); // R4
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy_n ##1 !busy_n) |-> $stable(result_q)); // R8
    AST_BUS_OFF: assert property (@(posedge clk) disable iff (rst)
        !data_oe |-> (data_o == '0)); // R6
    AST_HB_FOLD: assert property (@(posedge clk) disable iff (rst)
        (data_oe && hbyte) |-> (data_o[7:4] == 4'h0 && data_o[3:0] == data_o[11:8])); // R7
endmodule

bind sar_ctrl_core sar_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .hbyte      (hbyte),
    .busy_n     (busy_n),
    .trial_code (trial_code),
    .data_o     (data_o),
    .data_oe    (data_oe),
    .result_q   (result_w)
);

// File: tb/sar_ctrl_core_bench.sv
module sar_ctrl_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CONV_LEN   = 13;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        hbyte = 1'b0;
    logic [11:0] vin = '0;
    logic        cmp_hi;
    logic [11:0] trial_code;
    logic        busy_n;
    logic [11:0] data_o;
    logic        data_oe;

    int checks = 0;
    int errors = 0;
    logic [11:0] prev_word = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural comparator: input code against the trial word.
    assign cmp_hi = (vin >= trial_code);

    sar_ctrl_core u_sar_ctrl_core (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .hbyte(hbyte),
        .cmp_hi(cmp_hi), .trial_code(trial_code), .busy_n(busy_n),
        .data_o(data_o), .data_oe(data_oe)
    );

    function automatic logic [11:0] exp_view(logic [11:0] w, logic hb);
        return hb ? {w[11:8], 4'h0, w[11:8]} : w;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic release_bus();
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1; hbyte = 1'b0;
        #1;
        chk(data_oe == 1'b0 && data_o == 12'h000, "R6 bus off", {data_oe, data_o}, 0);
    endtask

    // Launch one conversion of code v; optionally poke select/read mid-way.
    task automatic convert(input logic [11:0] v, input int poke_at, input bit read_hb);
        int cnt;
        vin = v;
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; hbyte = 1'b0;
        #1;
        chk(data_oe == 1'b1, "R6 bus on", data_oe, 1);
        chk(data_o == prev_word, "R5 previous result word", data_o, prev_word);
        @(negedge clk);
        chk(busy_n == 1'b0, "R3 busy falls", busy_n, 0);
        chk(trial_code == 12'h000, "R4 trial cleared", trial_code, 0);
        chk(data_o == prev_word, "R8 old word at launch", data_o, prev_word);
        cs_n = 1'b1; rd_n = 1'b1;
        cnt = 1;
        @(negedge clk);
        chk(trial_code == 12'h800, "R4 msb trial", trial_code, 12'h800);
        while (busy_n == 1'b0 && cnt < 40) begin
            cnt++;
            if (poke_at != 0 && cnt == poke_at) begin
                cs_n = 1'b0; rd_n = 1'b0; hbyte = 1'b0;
                #1;
                chk(data_o == prev_word, "R8 old word mid conversion", data_o, prev_word);
            end else if (poke_at != 0 && cnt == poke_at + 1) begin
                cs_n = 1'b1; rd_n = 1'b1;
            end
            @(negedge clk);
        end
        cs_n = 1'b1; rd_n = 1'b1;
        chk(cnt == CONV_LEN, poke_at != 0 ? "R2 busy length with restart poke" : "R3 busy length",
            cnt, CONV_LEN);
        // Read back right after busy returns high.
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; hbyte = read_hb;
        #1;
        chk(data_o == exp_view(v, read_hb), read_hb ? "R7 folded view" : "R7 direct view",
            data_o, exp_view(v, read_hb));
        if (!read_hb) begin
            // A hbyte-low read launches again; wait it out.
            @(negedge clk);
            cs_n = 1'b1; rd_n = 1'b1;
            while (busy_n == 1'b0) @(negedge clk);
        end
        release_bus();
        prev_word = v;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(busy_n == 1'b1, "R9 busy after reset", busy_n, 1);
        chk(trial_code == 12'h000, "R9 trial after reset", trial_code, 0);
        cs_n = 1'b0; rd_n = 1'b0; hbyte = 1'b1;
        #1;
        chk(data_o == 12'h000, "R9 latch after reset", data_o, 0);
        // R1: hbyte high blocks the launch
        repeat (3) begin
            @(negedge clk);
            chk(busy_n == 1'b1, "R1 hbyte blocks launch", busy_n, 1);
        end
        release_bus();
        // R1: single strobe does not launch
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(busy_n == 1'b1, "R1 chip select alone", busy_n, 1);
        end
        #1;
        chk(data_oe == 1'b0, "R6 no enable without read", data_oe, 0);
        release_bus();

        // Directed corners
        convert(12'h000, 0, 1'b1);
        convert(12'hFFF, 0, 1'b1);
        convert(12'h800, 5, 1'b1);
        convert(12'h7FF, 12, 1'b0);
        convert(12'hA5A, 3, 1'b1);

        // Random conversions
        for (int i = 0; i < 30; i++) begin
            logic [11:0] v;
            int pk;
            v  = 12'($urandom);
            pk = ($urandom % 3 == 0) ? 0 : int'(2 + $urandom % 11);
            convert(v, pk, 1'($urandom));
        end
        // Final R5 check of last word
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; hbyte = 1'b0;
        #1;
        chk(data_o == prev_word, "R5 last result", data_o, prev_word);
        release_bus();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule